// File: doc/BRIEF.md
# Multi-Sector Erase Scheduler with Suspend

This block schedules the erasure of sectors inside a byte-wide flash emulator whose array is split into eight equal sectors. It takes decoded command strobes (sector erase, chip erase, suspend, resume, reset and a catch-all for every other command) together with a 3-bit sector index. Sector-erase requests collect into a selection mask while a timeout window stays open. Every new request restarts the full window. When the window expires, the block walks the array port. Each selected sector that is not protected gets two passes: every byte is first written with 00h, and then every byte is written with FFh.

Reads are sent to the block as a strobe plus a sector index. The block reports whether the read returns status instead of array data, and supplies the status byte. A suspend can end the window at once, or it can pause an active erase after a bounded delay. While the erase is paused, sectors outside the selection read normally. The window length, the suspend latency, the all-protected dwell, the per-byte step length and the fault limit are all parameters counted in clock cycles.

Top module: `sector_erase_sched`

## Requirements
- R1: The sector index of an array write is `arr_addr[ADDR_W-1:ADDR_W-3]`. Writes reach only sectors that are in the selection mask and whose `prot_mask` bit is 0. Sectors that are not selected or are protected keep their contents.
- R2: A sector-erase strobe opens a window of WIN_CYC cycles. A further sector-erase strobe inside the window adds its sector and restarts the full window. While the window is open, every read returns status (`rd_status`=1) with bit 3 = 0 and bit 7 = 0.
- R3: A chip-erase, resume, reset or other-command strobe during the window discards the selection. The block returns to array reads and writes nothing.
- R4: After the window, every byte of each eligible sector is written 00h and later FFh. Bit 3 of status is 1 once erasing has begun. When erasing finishes, reads return array data (`rd_status`=0).
- R5: If no selected sector is unprotected, status is shown for ALLPROT_CYC cycles after the window. The block then returns to array reads without any write.
- R6: During an active erase, status bit 7 is 0 and bit 6 inverts after every status read. Sector-erase strobes during this time are ignored.
- R7: A suspend during the window suspends at once and performs no write. A suspend during an active erase stops array writes within SUSP_CYC+1 cycles.
- R8: While suspended, a read inside a selected sector returns status with bit 7 = 1 and bit 6 unchanged between reads. A read in any other sector returns array data.
- R9: Resume continues the erase to completion. A second resume has no effect, and a later suspend is honoured again.
- R10: A suspend is ignored during a chip erase and while `pgm_active` is 1.
- R11: A chip-erase strobe in idle selects all eight sectors and starts erasing with no window.
- R12: When the active-erase cycle count passes FAULT_LIMIT, erasing halts and status bit 5 reads 1. This holds, through any command other than `cmd_reset`, until a `cmd_reset` strobe returns the block to array reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_sec_erase | input | 1 | Sector-erase command strobe |
| cmd_chip_erase | input | 1 | Chip-erase command strobe |
| cmd_suspend | input | 1 | Suspend command strobe |
| cmd_resume | input | 1 | Resume command strobe |
| cmd_reset | input | 1 | Reset command strobe |
| cmd_misc | input | 1 | Any other decoded command strobe |
| cmd_sector | input | 3 | Sector index carried with a sector-erase strobe |
| pgm_active | input | 1 | A byte program is in progress |
| prot_mask | input | 8 | Per-sector protect flags |
| rd_en | input | 1 | Read strobe |
| rd_sector | input | 3 | Sector index of the read |
| rd_status | output | 1 | This read returns status instead of array data |
| stat_byte | output | 8 | Status: bit7 polling, bit6 toggle, bit5 fault, bit3 erase begun, other bits 0 |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | 8 | Array write data |

## Verification
On every cycle, the assertions check the following. Array writes land only in selected, unprotected sectors. The all-protected dwell and the suspended state never write. Bit 3 reads 0 inside the window and bit 7 reads 0 while erasing. A stray command collapses the window to idle. A chip erase never enters the suspend path, and the fault state holds until reset. The bench scenarios are needed for the behaviour that spans many cycles: the window restart measured against elapsed cycles, the 00h-before-FFh order and the final contents of each sector, the suspend latency, resume after a pause, an ignored second resume, and the fault reached through a long chip erase.

// File: rtl/ses_pkg.sv
package ses_pkg;
  localparam int unsigned NSEC  = 8;
  localparam int unsigned SEC_W = 3;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_WIN    = 3'd1,
    S_RUN    = 3'd2,
    S_SPEND  = 3'd3,
    S_SUSP   = 3'd4,
    S_NOPROT = 3'd5,
    S_FAULT  = 3'd6
  } ses_st_e;
endpackage

// File: rtl/ses_timer.sv
// Down-counter: load arms it with CYC-1, it counts while run is high,
// and it reports expiry on the cycle it sits at zero while running.
module ses_timer #(
  parameter int unsigned CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);
  localparam int unsigned CW = (CYC > 1) ? $clog2(CYC) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) cnt_d = CW'(CYC - 1);
    else if (run && (cnt_q != '0)) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = run && (cnt_q == '0);
endmodule

// File: rtl/ses_engine.sv
// Walks the sectors in ascending order. Each eligible sector gets a
// zero pass and then a ones pass, one byte every STEP_CYC cycles.
module ses_engine #(
  parameter int unsigned ADDR_W   = 17,
  parameter int unsigned STEP_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              run,
  input  logic [7:0]        elig,
  output logic              we,
  output logic [ADDR_W-1:0] addr,
  output logic [7:0]        wdata,
  output logic              done
);
  localparam int unsigned OFF_W = ADDR_W - ses_pkg::SEC_W;
  localparam int unsigned SW    = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;

  logic [2:0]       sec_q, sec_d;
  logic             fin_q, fin_d;
  logic             ph_q, ph_d;
  logic [OFF_W-1:0] off_q, off_d;
  logic [SW-1:0]    stp_q, stp_d;
  logic             adv;

  always_comb begin
    sec_d = sec_q;
    fin_d = fin_q;
    ph_d  = ph_q;
    off_d = off_q;
    stp_d = stp_q;
    we    = 1'b0;
    adv   = 1'b0;
    if (clr) begin
      sec_d = '0;
      fin_d = 1'b0;
      ph_d  = 1'b0;
      off_d = '0;
      stp_d = '0;
    end else if (run && !fin_q) begin
      if (!elig[sec_q]) begin
        adv = 1'b1;
      end else begin
        we = (stp_q == '0);
        if (stp_q == SW'(STEP_CYC - 1)) begin
          stp_d = '0;
          if (off_q == {OFF_W{1'b1}}) begin
            off_d = '0;
            ph_d  = ~ph_q;
            adv   = ph_q;
          end else begin
            off_d = off_q + 1'b1;
          end
        end else begin
          stp_d = stp_q + 1'b1;
        end
      end
      if (adv) begin
        if (sec_q == 3'd7) fin_d = 1'b1;
        else               sec_d = sec_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;
      fin_q <= 1'b0;
      ph_q  <= 1'b0;
      off_q <= '0;
      stp_q <= '0;
    end else begin
      sec_q <= sec_d;
      fin_q <= fin_d;
      ph_q  <= ph_d;
      off_q <= off_d;
      stp_q <= stp_d;
    end
  end

  assign addr  = {sec_q, off_q};
  assign wdata = ph_q ? 8'hFF : 8'h00;
  assign done  = fin_q;
endmodule

// File: rtl/ses_status.sv
// Decides whether a read returns status and forms the status byte.
module ses_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       show_all,
  input  logic       susp,
  input  logic       win,
  input  logic       fault,
  input  logic [7:0] sel,
  input  logic       rd_en,
  input  logic [2:0] rd_sector,
  output logic       rd_status,
  output logic [7:0] stat_byte
);
  logic tog_q, tog_d;

  assign rd_status = show_all || (susp && sel[rd_sector]);

  always_comb begin
    tog_d = tog_q;
    if (rd_en && rd_status && !susp) tog_d = ~tog_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= tog_d;
  end

  assign stat_byte = {susp, tog_q, fault, 1'b0, ~win, 3'b000};
endmodule

// File: rtl/sector_erase_sched.sv
module sector_erase_sched #(
  parameter int unsigned ADDR_W      = 17,
  parameter int unsigned STEP_CYC    = 4,
  parameter int unsigned WIN_CYC     = 6250,
  parameter int unsigned SUSP_CYC    = 2500,
  parameter int unsigned ALLPROT_CYC = 12500,
  parameter int unsigned FAULT_LIMIT = 2000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_sec_erase,
  input  logic              cmd_chip_erase,
  input  logic              cmd_suspend,
  input  logic              cmd_resume,
  input  logic              cmd_reset,
  input  logic              cmd_misc,
  input  logic [2:0]        cmd_sector,
  input  logic              pgm_active,
  input  logic [7:0]        prot_mask,
  input  logic              rd_en,
  input  logic [2:0]        rd_sector,
  output logic              rd_status,
  output logic [7:0]        stat_byte,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [7:0]        arr_wdata
);
  import ses_pkg::*;

  localparam int unsigned FW = $clog2(FAULT_LIMIT + 1);

  logic [1:0]    rs_q;
  logic          rst_i;
  ses_st_e       st_q, st_d;
  logic [7:0]    sel_q, sel_d;
  logic          chip_q, chip_d;
  logic [FW-1:0] flt_q, flt_d;
  logic [7:0]    cbit, elig;
  logic          any_elig, running, flt_hit;
  logic          win_load, win_exp, spd_load, spd_exp, np_load, np_exp;
  logic          eng_done, eng_clr;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  assign cbit     = 8'b1 << cmd_sector;
  assign elig     = sel_q & ~prot_mask;
  assign any_elig = |elig;
  assign running  = (st_q == S_RUN) || (st_q == S_SPEND);
  assign flt_hit  = running && (flt_q == FW'(FAULT_LIMIT));
  assign win_load = cmd_sec_erase && ((st_q == S_IDLE) || (st_q == S_WIN));
  assign spd_load = (st_q == S_RUN) && cmd_suspend && !chip_q && !pgm_active;
  assign np_load  = (st_d == S_NOPROT) && (st_q != S_NOPROT);
  assign eng_clr  = (st_q == S_IDLE) || (st_q == S_WIN);

  always_comb begin
    st_d   = st_q;
    sel_d  = sel_q;
    chip_d = chip_q;
    unique case (st_q)
      S_IDLE: begin
        chip_d = 1'b0;
        if (cmd_chip_erase) begin
          sel_d  = 8'hFF;
          chip_d = 1'b1;
          st_d   = (|(~prot_mask)) ? S_RUN : S_NOPROT;
        end else if (cmd_sec_erase) begin
          sel_d = cbit;
          st_d  = S_WIN;
        end
      end
      S_WIN: begin
        if (cmd_sec_erase) begin
          sel_d = sel_q | cbit;
        end else if (cmd_suspend) begin
          st_d = S_SUSP;
        end else if (cmd_chip_erase || cmd_resume || cmd_reset || cmd_misc) begin
          st_d  = S_IDLE;
          sel_d = '0;
        end else if (win_exp) begin
          st_d = any_elig ? S_RUN : S_NOPROT;
        end
      end
      S_RUN, S_SPEND: begin
        if (flt_hit) begin
          st_d = S_FAULT;
        end else if (eng_done) begin
          st_d  = S_IDLE;
          sel_d = '0;
        end else if (spd_load) begin
          st_d = S_SPEND;
        end else if ((st_q == S_SPEND) && spd_exp) begin
          st_d = S_SUSP;
        end
      end
      S_SUSP: begin
        if (cmd_resume) st_d = any_elig ? S_RUN : S_NOPROT;
      end
      S_NOPROT: begin
        if (np_exp) begin
          st_d  = S_IDLE;
          sel_d = '0;
        end
      end
      S_FAULT: begin
        if (cmd_reset) begin
          st_d   = S_IDLE;
          sel_d  = '0;
          chip_d = 1'b0;
        end
      end
      default: begin
        st_d  = S_IDLE;
        sel_d = '0;
      end
    endcase
  end

  always_comb begin
    flt_d = flt_q;
    if (eng_clr)      flt_d = '0;
    else if (running && !flt_hit) flt_d = flt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st_q   <= S_IDLE;
      sel_q  <= '0;
      chip_q <= 1'b0;
      flt_q  <= '0;
    end else begin
      st_q   <= st_d;
      sel_q  <= sel_d;
      chip_q <= chip_d;
      flt_q  <= flt_d;
    end
  end

  ses_timer #(.CYC(WIN_CYC)) u_win (
    .clk(clk), .rst_n(rst_i), .load(win_load),
    .run(st_q == S_WIN), .expired(win_exp)
  );

  ses_timer #(.CYC(SUSP_CYC)) u_spd (
    .clk(clk), .rst_n(rst_i), .load(spd_load),
    .run(st_q == S_SPEND), .expired(spd_exp)
  );

  ses_timer #(.CYC(ALLPROT_CYC)) u_np (
    .clk(clk), .rst_n(rst_i), .load(np_load),
    .run(st_q == S_NOPROT), .expired(np_exp)
  );

  ses_engine #(.ADDR_W(ADDR_W), .STEP_CYC(STEP_CYC)) u_eng (
    .clk(clk), .rst_n(rst_i), .clr(eng_clr), .run(running), .elig(elig),
    .we(arr_we), .addr(arr_addr), .wdata(arr_wdata), .done(eng_done)
  );

  ses_status u_stat (
    .clk(clk), .rst_n(rst_i),
    .show_all((st_q == S_WIN) || running || (st_q == S_NOPROT) || (st_q == S_FAULT)),
    .susp(st_q == S_SUSP), .win(st_q == S_WIN), .fault(st_q == S_FAULT),
    .sel(sel_q), .rd_en(rd_en), .rd_sector(rd_sector),
    .rd_status(rd_status), .stat_byte(stat_byte)
  );
endmodule

// File: rtl/ses_chk.sv
module ses_chk #(
  parameter int unsigned ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input ses_pkg::ses_st_e  st_q,
  input logic [7:0]        sel_q,
  input logic              chip_q,
  input logic [7:0]        prot_mask,
  input logic              cmd_sec_erase,
  input logic              cmd_suspend,
  input logic              cmd_misc,
  input logic              cmd_reset,
  input logic              rd_status,
  input logic [7:0]        stat_byte,
  input logic              arr_we,
  input logic [ADDR_W-1:0] arr_addr
);
  import ses_pkg::*;

  a_r1_write_in_selected: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> (sel_q[arr_addr[ADDR_W-1 -: 3]] && !prot_mask[arr_addr[ADDR_W-1 -: 3]]));

  a_r2_dq3_low_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status && st_q == S_WIN) |-> !stat_byte[3]);

  a_r3_abort_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WIN && cmd_misc && !cmd_sec_erase && !cmd_suspend) |=> (st_q == S_IDLE));

  a_r5_noprot_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_NOPROT) |-> !arr_we);

  a_r6_dq7_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status && st_q == S_RUN) |-> !stat_byte[7]);

  a_r8_susp_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_SUSP) |-> !arr_we);

  a_r10_chip_no_suspend: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_RUN && chip_q) |=> (st_q != S_SPEND));

  a_r12_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_FAULT && !cmd_reset) |=> (st_q == S_FAULT));
endmodule

bind sector_erase_sched ses_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .st_q(st_q), .sel_q(sel_q), .chip_q(chip_q),
  .prot_mask(prot_mask), .cmd_sec_erase(cmd_sec_erase), .cmd_suspend(cmd_suspend),
  .cmd_misc(cmd_misc), .cmd_reset(cmd_reset), .rd_status(rd_status),
  .stat_byte(stat_byte), .arr_we(arr_we), .arr_addr(arr_addr)
);

// File: tb/tb_sector_erase_sched.sv
`timescale 1ns/1ps
module tb_sector_erase_sched;
  localparam int unsigned AW   = 9;
  localparam int unsigned SZ   = 1 << AW;
  localparam int unsigned SB   = SZ / 8;
  localparam int unsigned STEP = 2;
  localparam int unsigned WIN  = 20;
  localparam int unsigned SUSP = 5;
  localparam int unsigned NP   = 30;
  localparam int unsigned FL   = 1000;

  // {erase commands issued, protect flags, sectors expected erased}
  localparam logic [23:0] VEC [4] = '{
    {8'b0000_0001, 8'b0000_0000, 8'b0000_0001},
    {8'b1010_0100, 8'b0010_0000, 8'b1000_0100},
    {8'b0000_0011, 8'b0000_0000, 8'b0000_0011},
    {8'b1000_0000, 8'b1000_0000, 8'b0000_0000}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_sec_erase, cmd_chip_erase, cmd_suspend, cmd_resume, cmd_reset, cmd_misc;
  logic [2:0] cmd_sector, rd_sector;
  logic pgm_active, rd_en, rd_status, arr_we;
  logic [7:0] prot_mask, stat_byte, arr_wdata;
  logic [AW-1:0] arr_addr;

  int n_chk = 0, n_bad = 0, wr_cnt = 0, ord_err = 0;
  logic [7:0] mem [SZ];
  logic [7:0] ref_m [SZ];
  logic       seen0 [SZ];

  always #4 clk = ~clk;

  sector_erase_sched #(.ADDR_W(AW), .STEP_CYC(STEP), .WIN_CYC(WIN), .SUSP_CYC(SUSP),
                       .ALLPROT_CYC(NP), .FAULT_LIMIT(FL)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_sec_erase(cmd_sec_erase), .cmd_chip_erase(cmd_chip_erase),
    .cmd_suspend(cmd_suspend), .cmd_resume(cmd_resume), .cmd_reset(cmd_reset),
    .cmd_misc(cmd_misc), .cmd_sector(cmd_sector), .pgm_active(pgm_active),
    .prot_mask(prot_mask), .rd_en(rd_en), .rd_sector(rd_sector), .rd_status(rd_status),
    .stat_byte(stat_byte), .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata)
  );

  // array model: one write per cycle where arr_we is high
  always @(negedge clk) begin
    if (rst_n && arr_we) begin
      wr_cnt++;
      if (arr_wdata == 8'hFF && !seen0[arr_addr]) ord_err++;
      if (arr_wdata == 8'h00) seen0[arr_addr] = 1'b1;
      mem[arr_addr] = arr_wdata;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input int kind, input logic [2:0] s);
    @(negedge clk);
    cmd_sector = s;
    case (kind)
      0: cmd_sec_erase  = 1'b1;
      1: cmd_chip_erase = 1'b1;
      2: cmd_suspend    = 1'b1;
      3: cmd_resume     = 1'b1;
      4: cmd_reset      = 1'b1;
      default: cmd_misc = 1'b1;
    endcase
    @(negedge clk);
    {cmd_sec_erase, cmd_chip_erase, cmd_suspend, cmd_resume, cmd_reset, cmd_misc} = '0;
  endtask

  task automatic rd(input logic [2:0] s, output logic st, output logic [7:0] b);
    @(negedge clk);
    rd_en = 1'b1;
    rd_sector = s;
    #1;
    st = rd_status;
    b  = stat_byte;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    logic st;
    logic [7:0] b;
    cyc = 0;
    for (int i = 0; i < 6000; i++) begin
      rd(3'd0, st, b);
      cyc += 2;
      if (!st) break;
    end
  endtask

  task automatic preload();
    for (int i = 0; i < SZ; i++) begin
      mem[i]   = 8'((i * 37) + 11);
      ref_m[i] = mem[i];
      seen0[i] = 1'b0;
    end
    ord_err = 0;
  endtask

  task automatic verify(input logic [7:0] exp_mask, input string req);
    int bad = 0;
    for (int i = 0; i < SZ; i++) begin
      logic [7:0] e;
      e = exp_mask[i / SB] ? 8'hFF : ref_m[i];
      if (mem[i] != e) bad++;
    end
    chk(bad == 0, req, bad, 0);
    chk(ord_err == 0, "R4 zero pass precedes ones pass", ord_err, 0);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic st, st2;
    logic [7:0] b, b2;
    int cyc, wc;
    rst_n = 1'b0;
    {cmd_sec_erase, cmd_chip_erase, cmd_suspend, cmd_resume, cmd_reset, cmd_misc} = '0;
    cmd_sector = '0; rd_sector = '0; rd_en = 1'b0; pgm_active = 1'b0; prot_mask = '0;
    preload();
    idle_cyc(4);
    rst_n = 1'b1;
    idle_cyc(4);

    // reset state: array reads, no writes (R4)
    rd(3'd0, st, b);
    chk(!st, "R4 reset reads array", st, 0);
    chk(wr_cnt == 0, "R4 reset no writes", wr_cnt, 0);

    // vector table (R1, R4, R5)
    for (int v = 0; v < 4; v++) begin
      preload();
      prot_mask = VEC[v][15:8];
      for (int s = 0; s < 8; s++)
        if (VEC[v][16 + s]) strobe(0, 3'(s));
      wc = wr_cnt;
      wait_done(cyc);
      if (VEC[v][7:0] == 8'h00) begin
        chk(cyc >= int'(NP), "R5 all-protected dwell", cyc, NP);
        chk(wr_cnt == wc, "R5 all-protected writes nothing", wr_cnt - wc, 0);
      end
      verify(VEC[v][7:0], "R1 R4 sector contents after erase");
    end
    prot_mask = '0;

    // window restart, DQ3, DQ6 toggle (R2, R4, R6)
    preload();
    strobe(0, 3'd1);
    idle_cyc(15);
    rd(3'd4, st, b);
    chk(st && !b[3] && !b[7], "R2 window status bits", {st, b}, 9'h100);
    strobe(0, 3'd6);
    idle_cyc(15);
    rd(3'd4, st, b);
    chk(!b[3], "R2 window restarted by second command", b[3], 0);
    idle_cyc(10);
    rd(3'd4, st, b);
    rd(3'd4, st2, b2);
    chk(b[3], "R4 erase begun bit", b[3], 1);
    chk(!b[7] && !b2[7], "R6 polling bit low while erasing", {b[7], b2[7]}, 0);
    chk(b[6] != b2[6], "R6 toggle inverts per read", b2[6], !b[6]);
    wait_done(cyc);
    verify(8'b0100_0010, "R2 both windowed sectors erased");

    // abort inside window (R3)
    preload();
    wc = wr_cnt;
    strobe(0, 3'd2);
    idle_cyc(3);
    strobe(5, 3'd0);
    idle_cyc(30);
    rd(3'd2, st, b);
    chk(!st, "R3 abort returns to array reads", st, 0);
    chk(wr_cnt == wc, "R3 abort writes nothing", wr_cnt - wc, 0);

    // sector erase during active erase is ignored (R6)
    preload();
    strobe(0, 3'd1);
    idle_cyc(WIN + 5);
    strobe(0, 3'd4);
    wait_done(cyc);
    verify(8'b0000_0010, "R6 late sector-erase ignored");

    // suspend during window, reads while suspended, resume (R7, R8, R9)
    preload();
    strobe(0, 3'd3);
    idle_cyc(3);
    strobe(2, 3'd0);
    wc = wr_cnt;
    rd(3'd3, st, b);
    rd(3'd3, st2, b2);
    chk(st && b[7], "R8 suspended selected sector polling high", {st, b[7]}, 2'b11);
    chk(b[6] == b2[6], "R8 toggle steady while suspended", b2[6], b[6]);
    rd(3'd0, st, b);
    chk(!st, "R8 other sector reads array", st, 0);
    idle_cyc(50);
    chk(wr_cnt == wc, "R7 window suspend writes nothing", wr_cnt - wc, 0);
    strobe(3, 3'd0);
    strobe(3, 3'd0);
    idle_cyc(10);
    rd(3'd3, st, b);
    chk(st && !b[7], "R9 resumed erase running", {st, b[7]}, 2'b10);
    wait_done(cyc);
    verify(8'b0000_1000, "R9 erase completes after resume");

    // suspend during active erase, twice (R7, R9)
    preload();
    strobe(0, 3'd5);
    strobe(0, 3'd6);
    idle_cyc(WIN + 40);
    strobe(2, 3'd0);
    idle_cyc(SUSP + 2);
    wc = wr_cnt;
    idle_cyc(30);
    chk(wr_cnt == wc, "R7 writes stop after suspend latency", wr_cnt - wc, 0);
    rd(3'd5, st, b);
    chk(st && b[7], "R8 paused sector polling high", {st, b[7]}, 2'b11);
    strobe(3, 3'd0);
    idle_cyc(40);
    chk(wr_cnt > wc, "R9 resume restarts writes", wr_cnt - wc, 1);
    strobe(2, 3'd0);
    idle_cyc(SUSP + 2);
    wc = wr_cnt;
    idle_cyc(20);
    chk(wr_cnt == wc, "R9 second suspend honoured", wr_cnt - wc, 0);
    strobe(3, 3'd0);
    wait_done(cyc);
    verify(8'b0110_0000, "R9 paused erase completes");

    // chip erase: no window, suspend ignored (R10, R11)
    preload();
    prot_mask = 8'b1111_1100;
    strobe(1, 3'd0);
    rd(3'd0, st, b);
    chk(st && b[3], "R11 chip erase starts without window", {st, b[3]}, 2'b11);
    strobe(2, 3'd0);
    idle_cyc(SUSP + 2);
    wc = wr_cnt;
    idle_cyc(20);
    chk(wr_cnt > wc, "R10 suspend ignored in chip erase", wr_cnt - wc, 1);
    wait_done(cyc);
    verify(8'b0000_0011, "R11 chip erase covers unprotected sectors");
    prot_mask = '0;

    // suspend ignored while a program is active (R10)
    preload();
    strobe(0, 3'd7);
    idle_cyc(WIN + 10);
    pgm_active = 1'b1;
    strobe(2, 3'd0);
    pgm_active = 1'b0;
    idle_cyc(SUSP + 10);
    rd(3'd7, st, b);
    chk(st && !b[7], "R10 suspend ignored during program", {st, b[7]}, 2'b10);
    wait_done(cyc);
    verify(8'b1000_0000, "R10 erase finishes normally");

    // fault after the cycle limit, sticky until reset (R12)
    preload();
    strobe(1, 3'd0);
    idle_cyc(FL + 100);
    rd(3'd2, st, b);
    chk(st && b[5], "R12 fault bit set", {st, b[5]}, 2'b11);
    wc = wr_cnt;
    strobe(5, 3'd0);
    idle_cyc(40);
    rd(3'd2, st, b);
    chk(st && b[5], "R12 fault holds through other command", {st, b[5]}, 2'b11);
    chk(wr_cnt == wc, "R12 erase halted", wr_cnt - wc, 0);
    strobe(4, 3'd0);
    idle_cyc(2);
    rd(3'd2, st, b);
    chk(!st, "R12 reset clears fault", st, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule